// File: doc/BRIEF.md
# Two-Speed Offset-Nulling Sample Controller

This block is the digital half of a sampled offset-correction loop. A free-running clock drives a divider. Each time the divider wraps, one sample is taken: a one-bit comparator decision is captured into a latch. The latched bit then moves a signed correction code one step, in the direction that opposes the sensed error. The code is meant to feed a DAC that produces the correction voltage. The analog comparator, the DAC and the attenuator sit outside this block.

The controller works at two speeds. After reset it samples on every clock, so a large initial error is pulled in quickly. The first time the latched decision changes state, the loop is taken to have crossed null. From then on the divider runs at the slower ratio chosen by two select pins. Those pins can be changed freely after the switchover, and asserting reset again returns the block to full speed.

Top module: `offset_null_ctrl`

## Requirements
- R1: While `rst_n` is low, `cmp_q` reads 0, `corr_code` reads 0 and `sample_stb` stays low. Reset also re-arms full-speed operation.
- R2: Between reset release and the first change of `cmp_q`, a sample is taken on every clock edge, whatever the value of `rate_sel`.
- R3: When a sample makes `cmp_q` differ from its previous value for the first time since reset, the divide ratio switches to the one that `rate_sel` selects. The mapping is 2'b11 to 4, 2'b10 to 16, 2'b01 to 128 and 2'b00 to 1024 clocks per sample.
- R4: At each sampling edge, `cmp_q` takes the value of `cmp_in`. It keeps that value until the next sampling edge.
- R5: At each sample, a `cmp_in` of 1 lowers `corr_code` by one and a `cmp_in` of 0 raises it by one. Otherwise the code does not change.
- R6: `corr_code` is a 7-bit two's-complement value. It stops at +60 and -60, and a step past either limit leaves it unchanged.
- R7: `sample_stb` is high for exactly one clock after each sampling edge, which is when the new `cmp_q` and `corr_code` first appear. While the ratio stays the same, consecutive strobes are spaced by the ratio in clocks.
- R8: Any change of the active ratio restarts the divider. The first interval after the change lasts the new ratio plus one clock, and the intervals that follow last exactly the new ratio.
- R9: After the switchover, a new `rate_sel` value takes effect for the samples that follow. Once reset has been pulsed, the block again runs at full speed until the next first change of `cmp_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Selects the slow divide ratio |
| cmp_in | input | 1 | Comparator decision, where 1 means a positive error |
| cmp_q | output | 1 | Latched comparator decision |
| corr_code | output | 7 | Signed correction code |
| sample_stb | output | 1 | One-clock pulse after each sample |

## Verification
A stuck or wrong speed flag shows up as the wrong spacing between strobes. That spacing is visible at the next strobe: one clock when the block is wrongly at full speed, or up to 1025 clocks when it has slowed down too early. A wrong divider count or ratio code distorts that same interval. A wrong accumulator or latch value shows up as a wrong `corr_code` or `cmp_q` on the strobe that follows the bad sample. A saturation fault surfaces one sample after a limit is reached.

// File: rtl/offset_null_ctrl.sv
module offset_null_ctrl #(
  parameter int CODE_W   = 7,
  parameter int STEP_LIM = 60,
  parameter int DIV_W    = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               rate_sel,
  input  logic                     cmp_in,
  output logic                     cmp_q,
  output logic signed [CODE_W-1:0] corr_code,
  output logic                     sample_stb
);

  localparam logic signed [CODE_W-1:0] POS_LIM = CODE_W'(STEP_LIM);
  localparam logic signed [CODE_W-1:0] NEG_LIM = -POS_LIM;

  logic             fast_q;
  logic [2:0]       code_q, code_d;
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  function automatic logic [2:0] sel_code(input logic [1:0] s);
    case (s)
      2'b11:   return 3'd1;
      2'b10:   return 3'd2;
      2'b01:   return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] div_last(input logic [2:0] c);
    case (c)
      3'd0:    return '0;
      3'd1:    return DIV_W'(3);
      3'd2:    return DIV_W'(15);
      3'd3:    return DIV_W'(127);
      default: return DIV_W'(1023);
    endcase
  endfunction

  assign code_d = fast_q ? 3'd0 : sel_code(rate_sel);
  assign tick   = (code_d == code_q) && (cnt_q == div_last(code_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q     <= 1'b1;
      code_q     <= 3'd0;
      cnt_q      <= '0;
      cmp_q      <= 1'b0;
      corr_code  <= '0;
      sample_stb <= 1'b0;
    end else begin
      sample_stb <= tick;
      if (code_d != code_q) begin
        code_q <= code_d;
        cnt_q  <= '0;
      end else if (tick) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (tick) begin
        cmp_q <= cmp_in;
        if (cmp_in != cmp_q) fast_q <= 1'b0;
        if (cmp_in) begin
          if (corr_code != NEG_LIM) corr_code <= corr_code - 1'b1;
        end else begin
          if (corr_code != POS_LIM) corr_code <= corr_code + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/offset_null_ctrl_chk.sv
module offset_null_ctrl_chk #(
  parameter int CODE_W   = 7,
  parameter int STEP_LIM = 60
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmp_q,
  input logic signed [CODE_W-1:0] corr_code,
  input logic                     sample_stb,
  input logic                     fast_q
);

  localparam logic signed [CODE_W-1:0] POS_LIM = CODE_W'(STEP_LIM);
  localparam logic signed [CODE_W-1:0] NEG_LIM = -POS_LIM;

  assert_fast_every_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fast_q) && fast_q) |-> sample_stb);

  assert_slow_after_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && (cmp_q != $past(cmp_q))) |-> !fast_q);

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(cmp_q));

  assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(corr_code));

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && cmp_q) |->
      (corr_code == (($past(corr_code) == NEG_LIM) ? NEG_LIM : $past(corr_code) - 1'b1)));

  assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !cmp_q) |->
      (corr_code == (($past(corr_code) == POS_LIM) ? POS_LIM : $past(corr_code) + 1'b1)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_code >= NEG_LIM) && (corr_code <= POS_LIM));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !fast_q) |=> !sample_stb);

endmodule

bind offset_null_ctrl offset_null_ctrl_chk #(.CODE_W(CODE_W), .STEP_LIM(STEP_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_q(cmp_q), .corr_code(corr_code),
  .sample_stb(sample_stb), .fast_q(fast_q)
);

// File: tb/sim_offset_null_ctrl.sv
module sim_offset_null_ctrl;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        rate_sel = 2'b00;
  logic              cmp_in = 1'b0;
  logic              cmp_q;
  logic signed [6:0] corr_code;
  logic              sample_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int    q_gap[$];
  int    q_corr[$];
  bit    q_cmp[$];
  string q_tag[$];

  bit m_fast;
  bit m_last;
  bit m_first;
  int m_corr;
  int m_ratio;

  always #5 clk = ~clk;

  offset_null_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .cmp_in(cmp_in),
    .cmp_q(cmp_q), .corr_code(corr_code), .sample_stb(sample_stb)
  );

  function automatic int ratio_of(input logic [1:0] s);
    case (s)
      2'b11:   return 4;
      2'b10:   return 16;
      2'b01:   return 128;
      default: return 1024;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_sample(input bit c, input logic [1:0] s);
    int cur, gap;
    string tag;
    rate_sel = s;
    cmp_in   = c;
    cur = m_fast ? 1 : ratio_of(s);
    if (m_first) begin
      gap = -1;
      tag = "R2";
    end else if (cur != m_ratio) begin
      gap = cur + 1;
      tag = "R8";
    end else begin
      gap = cur;
      tag = m_fast ? "R2" : "R7";
    end
    m_first = 1'b0;
    m_ratio = cur;
    if (c) begin
      if (m_corr > -60) m_corr--;
    end else begin
      if (m_corr < 60) m_corr++;
    end
    if (m_fast && (c != m_last)) m_fast = 1'b0;
    m_last = c;
    q_gap.push_back(gap);
    q_corr.push_back(m_corr);
    q_cmp.push_back(c);
    q_tag.push_back(tag);
  endtask

  task automatic sample(input bit c, input logic [1:0] s);
    wait (q_gap.size() == 0);
    #1;
    push_sample(c, s);
  endtask

  task automatic do_reset(input bit c, input logic [1:0] s);
    wait (q_gap.size() == 0);
    #1;
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(cmp_q == 1'b0, "R1 cmp_q", int'(cmp_q), 0);
      check(corr_code == 0, "R1 corr_code", int'(corr_code), 0);
      check(sample_stb == 1'b0, "R1 sample_stb", int'(sample_stb), 0);
    end
    m_fast = 1'b1; m_last = 1'b0; m_first = 1'b1; m_corr = 0; m_ratio = 1;
    push_sample(c, s);
    #1 rst_n = 1'b1;
  endtask

  int gcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      gcnt = 0;
    end else begin
      gcnt++;
      if (sample_stb) begin
        if (q_gap.size() == 0) begin
          check(1'b0, "R7 unexpected strobe", 1, 0);
        end else begin
          int eg, ec;
          bit eb;
          string t;
          eg = q_gap.pop_front();
          ec = q_corr.pop_front();
          eb = q_cmp.pop_front();
          t  = q_tag.pop_front();
          check(cmp_q == eb, "R4 latched bit", int'(cmp_q), int'(eb));
          check(int'(corr_code) == ec, (ec == 60 || ec == -60) ? "R6 corr_code" : "R5 corr_code",
                int'(corr_code), ec);
          if (eg >= 0) check(gcnt == eg, {t, " strobe spacing"}, gcnt, eg);
        end
        gcnt = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0, 2'b00);
    // R2: full speed while rate_sel varies; R6: climb to +60 and hold
    for (int i = 0; i < 62; i++) sample(1'b0, 2'(i));
    // R3: first toggle switches to divide-by-4
    sample(1'b1, 2'b11);
    for (int i = 0; i < 124; i++) sample(1'b1, 2'b11);
    sample(1'b0, 2'b11);
    sample(1'b0, 2'b11);
    // R9: later select changes
    for (int i = 0; i < 3; i++) sample(1'b0, 2'b10);
    for (int i = 0; i < 2; i++) sample(1'b1, 2'b01);
    for (int i = 0; i < 2; i++) sample(1'b0, 2'b00);
    // R9: reset re-arms full speed
    do_reset(1'b0, 2'b11);
    sample(1'b0, 2'b11);
    sample(1'b1, 2'b11);
    for (int i = 0; i < 3; i++) sample(1'b1, 2'b11);
    wait (q_gap.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule